// File: doc/BRIEF.md
# Pipeline Valid-Bit Stall and Squash Control

This block controls the interstage registers of a five-stage in-order pipeline: fetch (IF), address computation (AC), operand fetch (OF), operate (OP) and operand store (OS). Each register feeding AC, OF, OP and OS holds a valid flag beside an opaque payload. The fetch stage's own flag says whether the instruction it currently presents is still live. Each stage's combinational result is handed in from outside and captured here. The block returns the register contents, their valid flags and the load enables that replace gated clocks.

Two lock levels freeze different prefixes of the pipe. The address lock freezes the PC and the AC register. The operand lock freezes the PC, the AC register and the OF register. The first register after a frozen prefix loads a bubble, so the stages that keep running never take a stalled result as a real instruction.

A branch raised by a live OS instruction squashes everything upstream and makes the PC take the branch target. A skip raised by a live OP instruction invalidates only the nearest live instruction behind it. That instruction is cleared in place if it is frozen, or arrives as a bubble if it moves. Requests and register writes from each stage leave the block only when that stage holds a live instruction.

Top module: `pipe_valid_ctl`

## Requirements
- R1: With both locks low and no branch, the PC load enable and every register load enable are 1. Each register takes its upstream stage's result, and its valid flag becomes the upstream flag, except where R7 applies. The fetch flag is set to 1 for the newly fetched instruction.
- R2: With the operand lock high and no branch, the PC, the AC register and the OF register do not load (en_o bits 0, 1 and 2 are 0). Their payloads and valid flags are unchanged, except where R7 applies, and the OS register still advances.
- R3: With only the address lock high and no branch, the PC and the AC register hold (en_o bits 0 and 1 are 0). The OP and OS registers advance. When both locks are high, the operand lock decides.
- R4: The register right after the frozen prefix loads a bubble: its valid flag becomes 0 whatever the frozen stage holds. This is the OF register (index 2) under the address lock and the OP register (index 3) under the operand lock.
- R5: Each req_o bit k equals req_i bit k ANDed with the valid flag of stage k, where index 0 is IF, 1 is AC, 2 is OF, 3 is OP and 4 is OS. A branch is ignored unless the OS flag is 1, and a skip is ignored unless the OP flag is 1.
- R6: An accepted branch has priority over both locks. In that cycle en_o is all ones and pc_branch_o is 1. On the next cycle the AC, OF, OP and OS flags are all 0 and the fetch flag is 1.
- R7: An accepted skip clears the valid flag of only the nearest younger live instruction, searching OF, then AC, then IF. A held instruction is cleared in place; a moving one arrives in its next register with flag 0. Every other flag follows R1 to R4.
- R8: While reset is asserted, the four register flags are 0 and the fetch flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_lock_i | input | 1 | Address lock: freeze the PC and the AC register |
| op_lock_i | input | 1 | Operand lock: freeze the PC, the AC register and the OF register |
| branch_i | input | 1 | Branch request from the OS stage |
| skip_i | input | 1 | Taken-skip request from the OP stage |
| stage_res_i | input | 4*PL_W | Results of stages IF, AC, OF, OP, in slots 0 to 3 |
| req_i | input | 5 | Raw request or write strobe of each stage, bit k is stage k |
| vld_o | output | 5 | Valid flags: bit 0 IF, bits 1 to 4 the AC to OS registers |
| pl_o | output | 4*PL_W | Register payloads; slot i feeds stage i+1 |
| en_o | output | 5 | Load enables: bit 0 PC, bits 1 to 4 the AC to OS registers |
| pc_branch_o | output | 1 | PC selects the branch target in this cycle |
| req_o | output | 5 | Requests gated by stage validity |

## Verification
The assertions take for granted that both lock levels are driven only as inputs. They also take for granted that a branch or skip arriving from an empty stage must be ignored, not acted on. Because of that, the properties guard each register against its own hold, bubble and flush conditions rather than against the upstream hazard logic. The stimulus draws locks, branches, skips and raw requests independently at random. It also raises branches and skips while OS or OP is empty, so the gating in R5 is exercised instead of being avoided. The bench holds tags in a bench-side model of the pipe. It feeds the fetch slot with a tag counter and loops each register's payload back as the next stage's result, so every hold, bubble and squash shows up as a tag that moves, stays or dies.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
    // stage indices; order matters for hold prefixes and skip search
    localparam int STG_IF   = 0;
    localparam int STG_AC   = 1;
    localparam int STG_OF   = 2;
    localparam int STG_OP   = 3;
    localparam int STG_OS   = 4;
    localparam int NSTG     = 5;
    localparam int NREG     = NSTG - 1;

    // number of leading entries (PC counts as entry 0) that freeze per lock level
    localparam int ADDR_FRZ_DEPTH = STG_AC + 1;
    localparam int OPND_FRZ_DEPTH = STG_OF + 1;

    // stage that raises a skip
    localparam int SKIP_STG = STG_OP;

    typedef enum logic [1:0] {
        FRZ_NONE = 2'd0,
        FRZ_ADDR = 2'd1,
        FRZ_OPND = 2'd2
    } frz_e;

    function automatic int frz_depth(frz_e f);
        case (f)
            FRZ_ADDR: return ADDR_FRZ_DEPTH;
            FRZ_OPND: return OPND_FRZ_DEPTH;
            default:  return 0;
        endcase
    endfunction
endpackage

// File: rtl/pipe_ctl_freeze.sv
module pipe_ctl_freeze
    import pipe_ctl_pkg::*;
(
    input  logic            ad_lock_i,
    input  logic            op_lock_i,
    input  logic            flush_i,
    output logic [NSTG-1:0] hold_o,
    output logic [NSTG-1:1] bubble_o
);
    frz_e level;
    int   depth;

    always_comb begin
        // operand lock covers a longer prefix, so it wins
        if (op_lock_i)      level = FRZ_OPND;
        else if (ad_lock_i) level = FRZ_ADDR;
        else                level = FRZ_NONE;
        depth = frz_depth(level);
    end

    generate
        for (genvar k = 0; k < NSTG; k++) begin : g_hold
            assign hold_o[k] = !flush_i && (k < depth);
        end
        for (genvar k = 1; k < NSTG; k++) begin : g_bub
            assign bubble_o[k] = !flush_i && (depth != 0) && (k == depth);
        end
    endgenerate

    always_comb begin
        a_one_bubble_r4: assert ($onehot0(bubble_o));
    end
endmodule

// File: rtl/pipe_ctl_skip.sv
module pipe_ctl_skip
    import pipe_ctl_pkg::*;
#(
    parameter int S = SKIP_STG
)(
    input  logic            skip_en_i,
    input  logic [S-1:0]    vld_i,
    output logic [NSTG-1:0] kill_o
);
    logic found;

    always_comb begin
        kill_o = '0;
        found  = 1'b0;
        // nearest younger live instruction first
        for (int j = S - 1; j >= 0; j--) begin
            if (skip_en_i && !found && vld_i[j]) begin
                kill_o[j] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        a_single_kill_r7: assert ($onehot0(kill_o));
    end
endmodule

// File: rtl/pipe_ctl_stage.sv
module pipe_ctl_stage #(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic         bubble_i,
    input  logic         flush_i,
    input  logic         up_vld_i,
    input  logic         up_kill_i,
    input  logic         own_kill_i,
    input  logic [W-1:0] up_pl_i,
    output logic         vld_o,
    output logic [W-1:0] pl_o,
    output logic         load_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] pl;
    } stg_t;

    stg_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = flush_i || !hold_i;
        if (flush_i) begin
            st_d.vld = 1'b0;
            st_d.pl  = up_pl_i;
        end else if (hold_i) begin
            st_d.vld = st_q.vld && !own_kill_i;
        end else if (bubble_i) begin
            st_d.vld = 1'b0;
            st_d.pl  = up_pl_i;
        end else begin
            st_d.vld = up_vld_i && !up_kill_i;
            st_d.pl  = up_pl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign pl_o  = st_q.pl;

    // R2 and R3: a frozen register keeps its payload
    p_hold_pl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !flush_i) |=> (pl_o == $past(pl_o)));
    p_hold_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !flush_i && !own_kill_i) |=> (vld_o == $past(vld_o)));
    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble_i && !flush_i) |=> !vld_o);
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !vld_o);
    p_skip_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_kill_i && !flush_i && !hold_i && !bubble_i) |=> !vld_o);
    p_skip_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_kill_i && hold_i && !flush_i) |=> !vld_o);
    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !hold_i && !bubble_i && !up_kill_i)
        |=> (vld_o == $past(up_vld_i) && pl_o == $past(up_pl_i)));
endmodule

// File: rtl/pipe_valid_ctl.sv
module pipe_valid_ctl
    import pipe_ctl_pkg::*;
#(
    parameter int PL_W = 8
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ad_lock_i,
    input  logic                 op_lock_i,
    input  logic                 branch_i,
    input  logic                 skip_i,
    input  logic [NREG*PL_W-1:0] stage_res_i,
    input  logic [NSTG-1:0]      req_i,
    output logic [NSTG-1:0]      vld_o,
    output logic [NREG*PL_W-1:0] pl_o,
    output logic [NSTG-1:0]      en_o,
    output logic                 pc_branch_o,
    output logic [NSTG-1:0]      req_o
);
    logic [NSTG-1:0] vld;
    logic [NSTG-1:0] hold;
    logic [NSTG-1:1] bubble;
    logic [NSTG-1:0] kill;
    logic            br_eff;
    logic            sk_eff;
    logic            if_vld_d, if_vld_q;

    // a request from an empty stage is ignored
    assign br_eff = branch_i && vld[STG_OS];
    assign sk_eff = skip_i   && vld[SKIP_STG];

    pipe_ctl_freeze u_frz (
        .ad_lock_i (ad_lock_i),
        .op_lock_i (op_lock_i),
        .flush_i   (br_eff),
        .hold_o    (hold),
        .bubble_o  (bubble)
    );

    pipe_ctl_skip #(.S(SKIP_STG)) u_skip (
        .skip_en_i (sk_eff),
        .vld_i     (vld[SKIP_STG-1:0]),
        .kill_o    (kill)
    );

    // fetch-stage liveness: set on each new fetch, cleared by a skip while frozen
    always_comb begin
        if (br_eff)              if_vld_d = 1'b1;
        else if (hold[STG_IF])   if_vld_d = if_vld_q && !kill[STG_IF];
        else                     if_vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) if_vld_q <= 1'b1;
        else        if_vld_q <= if_vld_d;
    end

    assign vld[STG_IF]  = if_vld_q;
    assign en_o[STG_IF] = !hold[STG_IF];
    assign pc_branch_o  = br_eff;

    generate
        for (genvar k = 1; k < NSTG; k++) begin : g_stg
            pipe_ctl_stage #(.W(PL_W)) u_stg (
                .clk        (clk),
                .rst_n      (rst_n),
                .hold_i     (hold[k]),
                .bubble_i   (bubble[k]),
                .flush_i    (br_eff),
                .up_vld_i   (vld[k-1]),
                .up_kill_i  (kill[k-1]),
                .own_kill_i (kill[k]),
                .up_pl_i    (stage_res_i[(k-1)*PL_W +: PL_W]),
                .vld_o      (vld[k]),
                .pl_o       (pl_o[(k-1)*PL_W +: PL_W]),
                .load_o     (en_o[k])
            );
        end
    endgenerate

    assign vld_o = vld;
    assign req_o = req_i & vld;

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (vld_o == 5'b00001));
    p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && vld_o[STG_OS]) |=> (vld_o == 5'b00001));
    p_branch_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && vld_o[STG_OS]) |-> (en_o == 5'b11111 && pc_branch_o));
    p_lock_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ad_lock_i || op_lock_i) && !pc_branch_o) |-> !en_o[STG_IF]);
    p_os_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_branch_o |-> en_o[STG_OS]);
    p_skip_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_o[STG_OP] && !pc_branch_o && !ad_lock_i && !op_lock_i)
        |=> (vld_o[STG_OS] == $past(vld_o[STG_OP])));
endmodule

// File: tb/sim_pipe_valid_ctl.sv
module sim_pipe_valid_ctl;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ad_lock = 1'b0, op_lock = 1'b0, branch = 1'b0, skip = 1'b0;
    logic [4*W-1:0] stage_res;
    logic [4:0]     req = '0;
    logic [4:0]     vld_o, en_o, req_o;
    logic [4*W-1:0] pl_o;
    logic           pc_branch_o;

    // bench-side model state
    bit   [4:0]     mv;
    logic [W-1:0]   mp [1:4];
    logic [W-1:0]   tag;
    bit             killed [int];
    int             last_ret = -1;
    int             n_chk = 0, n_err = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    assign stage_res = {pl_o[2*W +: W], pl_o[W +: W], pl_o[0 +: W], tag};

    pipe_valid_ctl #(.PL_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ad_lock_i(ad_lock), .op_lock_i(op_lock),
        .branch_i(branch), .skip_i(skip), .stage_res_i(stage_res), .req_i(req),
        .vld_o(vld_o), .pl_o(pl_o), .en_o(en_o), .pc_branch_o(pc_branch_o),
        .req_o(req_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int frz(input bit ad, input bit op);
        return op ? 3 : (ad ? 2 : 0);
    endfunction

    function automatic bit [4:0] skip_kill(input bit ske, input bit [4:0] v);
        bit [4:0] k = '0;
        if (ske) begin
            if (v[2])      k[2] = 1'b1;
            else if (v[1]) k[1] = 1'b1;
            else if (v[0]) k[0] = 1'b1;
        end
        return k;
    endfunction

    // one cycle: drive at the falling edge, check after the next falling edge
    task automatic step(input bit ad, input bit op, input bit br, input bit sk,
                        input logic [4:0] rq, input string lab);
        int           f;
        bit           bre, ske;
        bit [4:0]     kl, nv, expen;
        logic [W-1:0] np [1:4];
        logic [W-1:0] ntag;
        ad_lock = ad; op_lock = op; branch = br; skip = sk; req = rq;
        f   = frz(ad, op);
        bre = br && mv[4];
        ske = sk && mv[3];
        kl  = skip_kill(ske, mv);
        expen[0] = bre || (f == 0);
        for (int k = 1; k < 5; k++) expen[k] = bre || (k >= f);
        #1;
        chk(en_o == expen, {lab, " R2/R3 load enables"}, en_o, expen);
        chk(pc_branch_o == bre, "R6 pc_branch_o", pc_branch_o, bre);
        chk(req_o == (rq & mv), "R5 gated requests", req_o, rq & mv);
        for (int k = 1; k < 5; k++) np[k] = mp[k];
        ntag = tag;
        if (bre) begin
            for (int k = 1; k < 4; k++) if (mv[k]) killed[mp[k]] = 1'b1;
            if (mv[0]) killed[tag] = 1'b1;
            nv   = 5'b00001;
            ntag = tag + 16;
        end else begin
            for (int k = 0; k < 4; k++) if (kl[k]) killed[(k == 0) ? tag : mp[k]] = 1'b1;
            for (int k = 1; k < 5; k++) begin
                if (k < f) nv[k] = mv[k] && !kl[k];
                else if (k == f) nv[k] = 1'b0;
                else begin
                    nv[k] = mv[k-1] && !kl[k-1];
                    np[k] = (k == 1) ? tag : mp[k-1];
                end
            end
            if (f > 0) nv[0] = mv[0] && !kl[0];
            else begin
                nv[0] = 1'b1;
                ntag  = tag + 1;
            end
        end
        @(negedge clk);
        mv  = nv;
        tag = ntag;
        for (int k = 1; k < 5; k++) mp[k] = np[k];
        chk(vld_o == mv, {lab, " valid flags"}, vld_o, mv);
        for (int k = 1; k < 5; k++)
            if (mv[k]) chk(pl_o[(k-1)*W +: W] == mp[k], {lab, " payload R1/R2"},
                           pl_o[(k-1)*W +: W], mp[k]);
        if (vld_o[4]) begin
            chk(!killed.exists(int'(pl_o[3*W +: W])), "R7/R6 squashed tag retired",
                pl_o[3*W +: W], 0);
            chk(int'(pl_o[3*W +: W]) > last_ret, "R2 tag duplicated or reordered",
                pl_o[3*W +: W], last_ret + 1);
            last_ret = pl_o[3*W +: W];
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        mv  = 5'b00001;
        tag = '0;
        for (int k = 1; k < 5; k++) mp[k] = '0;
        // R8: flags during reset
        repeat (3) @(negedge clk);
        chk(vld_o == 5'b00001, "R8 reset flags", vld_o, 5'b00001);
        chk(en_o == 5'b11111, "R8 R1 enables at reset", en_o, 5'b11111);
        rst_n = 1'b1;
        // R1: fill the pipe
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 5'b11111, "R1 fill");
        // R2, R4: operand lock
        step(0, 1, 0, 0, 5'b11111, "R2 R4 op lock");
        step(0, 1, 0, 0, 5'b10101, "R2 R4 op lock");
        // R3, R4: address lock, then both locks
        step(1, 0, 0, 0, 5'b01010, "R3 R4 addr lock");
        step(1, 0, 0, 0, 5'b11111, "R3 R4 addr lock");
        step(1, 1, 0, 0, 5'b11111, "R3 both locks");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 5'b11111, "R1 refill");
        // R7: skip while running and while the successor is frozen
        step(0, 0, 0, 1, 5'b11111, "R7 skip moving");
        step(0, 1, 0, 1, 5'b11111, "R7 skip held");
        step(0, 0, 0, 0, 5'b11111, "R7 after skip");
        // R6: branch wins over a lock
        step(0, 0, 0, 0, 5'b11111, "R1 run");
        step(1, 1, 1, 0, 5'b11111, "R6 branch with locks");
        // R5: branch and skip from empty stages are ignored
        step(0, 0, 1, 1, 5'b11111, "R5 branch/skip from empty");
        step(0, 0, 0, 0, 5'b11111, "R1 run");
        step(0, 0, 0, 0, 5'b11111, "R1 run");
        // R7: skip target inside the frozen address prefix
        step(1, 0, 0, 0, 5'b11111, "R3 addr lock");
        step(1, 0, 0, 1, 5'b11111, "R7 skip held in AC");
        step(1, 0, 0, 1, 5'b11111, "R7 skip held");
        step(0, 0, 0, 0, 5'b11111, "R1 release");
        // constrained random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            bit ad = ($urandom % 100) < 20;
            bit op = ($urandom % 100) < 15;
            bit br = ($urandom % 100) < 8;
            bit sk = ($urandom % 100) < 20;
            logic [4:0] rq = 5'($urandom);
            step(ad, op, br, sk, rq, "R1-mix R2 R3 R4 R6 R7");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule